// File: doc/BRIEF.md
# Aliased Multi-View Floating-Point Register Bank

This block holds a bank of 64 single-precision registers, 32 bits each, and lets a datapath reach that one storage through four views. A view has its own combinational read port and its own write port. The single view addresses any register directly. The double view joins two neighbouring registers into one 64-bit value. The vector view and the matrix view each mask their index and scale it, so that they reach only the base register of a vector or of a matrix.

No view has storage of its own. Each view is an index alias that is computed onto the shared array. A write through one view is therefore visible through every view that covers the same register. The block performs at most one write per clock. When several write ports request in the same cycle, a fixed priority picks the winner and the other requests are dropped. A double access at the last index has no partner register, so the block reports it as illegal. Reads show the contents as they stood after the previous clock edge.

Top module: `fpr_multiview`

## Requirements
- R1: After reset (active-low `rst_n`), all 64 registers read as zero through the single view.
- R2: A single write to index i (0..63) can be read at i after the next rising clock edge. A read of i in the same cycle as the write returns the old value.
- R3: A double read at index n (0..62) returns register n in bits 63:32 and register n+1 in bits 31:0. This holds for odd n as well as even n.
- R4: A double write at index n (0..62) stores bits 63:32 into register n and bits 31:0 into register n+1.
- R5: A double access at index 63 is illegal. On the read port, `dbl_rd_illegal` is 1, bits 63:32 hold register 63 and bits 31:0 are zero. On the write port, `dbl_wr_illegal` is 1 in the same cycle and no register changes.
- R6: The vector view uses only bits 3:0 of its 6-bit index v and reaches register 4*(v AND 15). Bits 5:4 of v have no effect.
- R7: The matrix view uses only bits 1:0 of its 6-bit index m and reaches register 16*(m AND 3). Bits 5:2 of m have no effect.
- R8: At most one write takes effect per cycle. The priority order is double, then single, then vector, then matrix. A losing request changes nothing.
- R9: With every write enable low, no register changes, whatever the write index and data inputs carry.
- R10: An illegal double write (R5) still wins arbitration. Any single, vector or matrix write requested in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sgl_rd_idx | input | 6 | Single-view read index |
| sgl_rd_data | output | 32 | Single-view read data |
| dbl_rd_idx | input | 6 | Double-view read index |
| dbl_rd_data | output | 64 | Double-view read data, register n in the upper half |
| dbl_rd_illegal | output | 1 | Double read index has no partner register |
| vec_rd_idx | input | 6 | Vector-view read index (bits 3:0 used) |
| vec_rd_data | output | 32 | Vector-view read data |
| mat_rd_idx | input | 6 | Matrix-view read index (bits 1:0 used) |
| mat_rd_data | output | 32 | Matrix-view read data |
| dbl_wr_en | input | 1 | Double-view write request |
| dbl_wr_idx | input | 6 | Double-view write index |
| dbl_wr_data | input | 64 | Double-view write data |
| dbl_wr_illegal | output | 1 | Requested double write is illegal and is discarded |
| sgl_wr_en | input | 1 | Single-view write request |
| sgl_wr_idx | input | 6 | Single-view write index |
| sgl_wr_data | input | 32 | Single-view write data |
| vec_wr_en | input | 1 | Vector-view write request |
| vec_wr_idx | input | 6 | Vector-view write index (bits 3:0 used) |
| vec_wr_data | input | 32 | Vector-view write data |
| mat_wr_en | input | 1 | Matrix-view write request |
| mat_wr_idx | input | 6 | Matrix-view write index (bits 1:0 used) |
| mat_wr_data | input | 32 | Matrix-view write data |

## Verification
The two functions that meet in one cycle are write arbitration between views and a read of a register that is being written in that same cycle.

Collisions are provoked in two ways. One is to raise two, three or four write enables together, with targets that do and do not overlap. The other is to put an illegal double write next to a lower-priority write.

A collision is judged by sweeping all 64 registers through the single view and comparing them with a model that applies only the winning request. A same-cycle read is judged by sampling the read port before the write edge and again after it.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    // Source selected by the write arbiter for the current cycle.
    typedef enum logic [2:0] {
        WR_NONE = 3'd0,
        WR_DBL  = 3'd1,
        WR_SGL  = 3'd2,
        WR_VEC  = 3'd3,
        WR_MAT  = 3'd4
    } wr_src_e;

endpackage

// File: rtl/fpr_view_map.sv
// Maps a view index onto a base register: keep the low KEEP_W bits, then
// scale by 2**SHIFT.
module fpr_view_map #(
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned KEEP_W = 4,
    parameter int unsigned SHIFT  = 2
) (
    input  logic [IDX_W-1:0] idx_in,
    output logic [IDX_W-1:0] reg_idx
);

    localparam logic [IDX_W-1:0] KEEP_MASK = IDX_W'((1 << KEEP_W) - 1);

    logic [IDX_W-1:0] kept;

    always_comb begin
        kept    = idx_in & KEEP_MASK;
        reg_idx = kept << SHIFT;
    end

endmodule

// File: rtl/fpr_wr_arbiter.sv
// Fixed-priority selection of the single write performed per cycle.
module fpr_wr_arbiter
    import fpr_pkg::*;
#(
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned WORD_W = 32
) (
    input  logic                  dbl_en,
    input  logic [IDX_W-1:0]      dbl_idx,
    input  logic [2*WORD_W-1:0]   dbl_data,
    input  logic                  sgl_en,
    input  logic [IDX_W-1:0]      sgl_idx,
    input  logic [WORD_W-1:0]     sgl_data,
    input  logic                  vec_en,
    input  logic [IDX_W-1:0]      vec_reg,
    input  logic [WORD_W-1:0]     vec_data,
    input  logic                  mat_en,
    input  logic [IDX_W-1:0]      mat_reg,
    input  logic [WORD_W-1:0]     mat_data,
    output logic                  wr_en,
    output logic                  wr_pair,
    output logic [IDX_W-1:0]      wr_idx,
    output logic [WORD_W-1:0]     wr_hi,
    output logic [WORD_W-1:0]     wr_lo,
    output logic                  dbl_illegal
);

    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    wr_src_e src;

    always_comb begin
        if (dbl_en)      src = WR_DBL;
        else if (sgl_en) src = WR_SGL;
        else if (vec_en) src = WR_VEC;
        else if (mat_en) src = WR_MAT;
        else             src = WR_NONE;
    end

    always_comb begin
        wr_en       = 1'b0;
        wr_pair     = 1'b0;
        wr_idx      = '0;
        wr_hi       = '0;
        wr_lo       = '0;
        dbl_illegal = dbl_en && (dbl_idx == LAST_IDX);
        case (src)
            WR_DBL: begin
                wr_en   = (dbl_idx != LAST_IDX);
                wr_pair = 1'b1;
                wr_idx  = dbl_idx;
                wr_hi   = dbl_data[2*WORD_W-1:WORD_W];
                wr_lo   = dbl_data[WORD_W-1:0];
            end
            WR_SGL: begin
                wr_en  = 1'b1;
                wr_idx = sgl_idx;
                wr_hi  = sgl_data;
            end
            WR_VEC: begin
                wr_en  = 1'b1;
                wr_idx = vec_reg;
                wr_hi  = vec_data;
            end
            WR_MAT: begin
                wr_en  = 1'b1;
                wr_idx = mat_reg;
                wr_hi  = mat_data;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fpr_storage.sv
// Shared single-precision array, one write per cycle, optionally a pair.
module fpr_storage #(
    parameter int unsigned NUM_REGS = 64,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             wr_pair,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [WORD_W-1:0]                wr_hi,
    input  logic [WORD_W-1:0]                wr_lo,
    output logic [NUM_REGS-1:0][WORD_W-1:0]  regs
);

    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] regs;
    } fpr_state_t;

    fpr_state_t st_d, st_q;
    logic [IDX_W-1:0] wr_idx_nxt;

    always_comb begin
        wr_idx_nxt = wr_idx + 1'b1;
        st_d       = st_q;
        if (wr_en) begin
            st_d.regs[wr_idx] = wr_hi;
            if (wr_pair) begin
                st_d.regs[wr_idx_nxt] = wr_lo;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q.regs;

endmodule

// File: rtl/fpr_multiview.sv
module fpr_multiview #(
    parameter int unsigned NUM_REGS   = 64,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned VEC_KEEP_W = 4,
    parameter int unsigned VEC_SHIFT  = 2,
    parameter int unsigned MAT_KEEP_W = 2,
    parameter int unsigned MAT_SHIFT  = 4,
    localparam int unsigned IDX_W     = $clog2(NUM_REGS),
    localparam int unsigned DBL_W     = 2 * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   sgl_rd_idx,
    output logic [WORD_W-1:0]  sgl_rd_data,
    input  logic [IDX_W-1:0]   dbl_rd_idx,
    output logic [DBL_W-1:0]   dbl_rd_data,
    output logic               dbl_rd_illegal,
    input  logic [IDX_W-1:0]   vec_rd_idx,
    output logic [WORD_W-1:0]  vec_rd_data,
    input  logic [IDX_W-1:0]   mat_rd_idx,
    output logic [WORD_W-1:0]  mat_rd_data,
    input  logic               dbl_wr_en,
    input  logic [IDX_W-1:0]   dbl_wr_idx,
    input  logic [DBL_W-1:0]   dbl_wr_data,
    output logic               dbl_wr_illegal,
    input  logic               sgl_wr_en,
    input  logic [IDX_W-1:0]   sgl_wr_idx,
    input  logic [WORD_W-1:0]  sgl_wr_data,
    input  logic               vec_wr_en,
    input  logic [IDX_W-1:0]   vec_wr_idx,
    input  logic [WORD_W-1:0]  vec_wr_data,
    input  logic               mat_wr_en,
    input  logic [IDX_W-1:0]   mat_wr_idx,
    input  logic [WORD_W-1:0]  mat_wr_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    logic [NUM_REGS-1:0][WORD_W-1:0] regs_q;
    logic [IDX_W-1:0] vec_rd_reg, vec_wr_reg, mat_rd_reg, mat_wr_reg;
    logic [IDX_W-1:0] dbl_rd_nxt;
    logic             wr_en, wr_pair;
    logic [IDX_W-1:0] wr_idx;
    logic [WORD_W-1:0] wr_hi, wr_lo;

    // Index aliasing for the scaled views, read and write side.
    fpr_view_map #(.IDX_W(IDX_W), .KEEP_W(VEC_KEEP_W), .SHIFT(VEC_SHIFT)) i_vec_rd_map (
        .idx_in(vec_rd_idx), .reg_idx(vec_rd_reg));
    fpr_view_map #(.IDX_W(IDX_W), .KEEP_W(VEC_KEEP_W), .SHIFT(VEC_SHIFT)) i_vec_wr_map (
        .idx_in(vec_wr_idx), .reg_idx(vec_wr_reg));
    fpr_view_map #(.IDX_W(IDX_W), .KEEP_W(MAT_KEEP_W), .SHIFT(MAT_SHIFT)) i_mat_rd_map (
        .idx_in(mat_rd_idx), .reg_idx(mat_rd_reg));
    fpr_view_map #(.IDX_W(IDX_W), .KEEP_W(MAT_KEEP_W), .SHIFT(MAT_SHIFT)) i_mat_wr_map (
        .idx_in(mat_wr_idx), .reg_idx(mat_wr_reg));

    fpr_wr_arbiter #(.IDX_W(IDX_W), .WORD_W(WORD_W)) i_arb (
        .dbl_en     (dbl_wr_en),
        .dbl_idx    (dbl_wr_idx),
        .dbl_data   (dbl_wr_data),
        .sgl_en     (sgl_wr_en),
        .sgl_idx    (sgl_wr_idx),
        .sgl_data   (sgl_wr_data),
        .vec_en     (vec_wr_en),
        .vec_reg    (vec_wr_reg),
        .vec_data   (vec_wr_data),
        .mat_en     (mat_wr_en),
        .mat_reg    (mat_wr_reg),
        .mat_data   (mat_wr_data),
        .wr_en      (wr_en),
        .wr_pair    (wr_pair),
        .wr_idx     (wr_idx),
        .wr_hi      (wr_hi),
        .wr_lo      (wr_lo),
        .dbl_illegal(dbl_wr_illegal)
    );

    fpr_storage #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W), .IDX_W(IDX_W)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_pair(wr_pair),
        .wr_idx (wr_idx),
        .wr_hi  (wr_hi),
        .wr_lo  (wr_lo),
        .regs   (regs_q)
    );

    // Combinational read views over the registered array.
    always_comb begin
        dbl_rd_nxt     = dbl_rd_idx + 1'b1;
        dbl_rd_illegal = (dbl_rd_idx == LAST_IDX);
        sgl_rd_data    = regs_q[sgl_rd_idx];
        vec_rd_data    = regs_q[vec_rd_reg];
        mat_rd_data    = regs_q[mat_rd_reg];
        dbl_rd_data[DBL_W-1:WORD_W] = regs_q[dbl_rd_idx];
        dbl_rd_data[WORD_W-1:0]     = dbl_rd_illegal ? '0 : regs_q[dbl_rd_nxt];
    end

endmodule

// File: rtl/fpr_multiview_chk.sv
module fpr_multiview_chk #(
    parameter int unsigned NUM_REGS = 64,
    parameter int unsigned WORD_W   = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned DBL_W   = 2 * WORD_W
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_REGS-1:0][WORD_W-1:0] regs_q,
    input logic                            dbl_wr_en,
    input logic [IDX_W-1:0]                dbl_wr_idx,
    input logic [DBL_W-1:0]                dbl_wr_data,
    input logic                            dbl_wr_illegal,
    input logic                            sgl_wr_en,
    input logic [IDX_W-1:0]                sgl_wr_idx,
    input logic [WORD_W-1:0]               sgl_wr_data,
    input logic                            vec_wr_en,
    input logic                            mat_wr_en,
    input logic [IDX_W-1:0]                dbl_rd_idx,
    input logic [DBL_W-1:0]                dbl_rd_data,
    input logic                            dbl_rd_illegal
);

    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    logic [NUM_REGS-1:0][WORD_W-1:0] prev_q;
    logic [NUM_REGS-1:0]             chg;
    logic [IDX_W-1:0]                dbl_wr_nxt;

    assign dbl_wr_nxt = dbl_wr_idx + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= regs_q;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
        assign chg[g] = (regs_q[g] != prev_q[g]);
    end

    // R8: one write per cycle, so at most a pair of registers changes.
    p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 2);

    // R2: a winning single write lands at its index.
    p_sgl_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sgl_wr_en && !dbl_wr_en) |=> regs_q[$past(sgl_wr_idx)] == $past(sgl_wr_data));

    // R4: a legal double write lands in both halves.
    p_dbl_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_wr_en && dbl_wr_idx != LAST_IDX) |=>
        regs_q[$past(dbl_wr_idx)] == $past(dbl_wr_data[DBL_W-1:WORD_W]));
    p_dbl_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_wr_en && dbl_wr_idx != LAST_IDX) |=>
        regs_q[$past(dbl_wr_nxt)] == $past(dbl_wr_data[WORD_W-1:0]));

    // R5 / R10: an illegal double write changes nothing, whatever else requests.
    p_illegal_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_wr_en && dbl_wr_idx == LAST_IDX) |-> dbl_wr_illegal);
    p_illegal_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_wr_en && dbl_wr_illegal) |=> $stable(regs_q));

    // R5: double read of the last index.
    p_dbl_rd_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_rd_idx == LAST_IDX) |->
        (dbl_rd_illegal && dbl_rd_data[WORD_W-1:0] == '0 &&
         dbl_rd_data[DBL_W-1:WORD_W] == regs_q[LAST_IDX]));

    // R9: no enable, no change.
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbl_wr_en || sgl_wr_en || vec_wr_en || mat_wr_en) |=> $stable(regs_q));

endmodule

bind fpr_multiview fpr_multiview_chk #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .regs_q        (regs_q),
    .dbl_wr_en     (dbl_wr_en),
    .dbl_wr_idx    (dbl_wr_idx),
    .dbl_wr_data   (dbl_wr_data),
    .dbl_wr_illegal(dbl_wr_illegal),
    .sgl_wr_en     (sgl_wr_en),
    .sgl_wr_idx    (sgl_wr_idx),
    .sgl_wr_data   (sgl_wr_data),
    .vec_wr_en     (vec_wr_en),
    .mat_wr_en     (mat_wr_en),
    .dbl_rd_idx    (dbl_rd_idx),
    .dbl_rd_data   (dbl_rd_data),
    .dbl_rd_illegal(dbl_rd_illegal)
);

// File: tb/test_fpr_multiview.sv
module test_fpr_multiview;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  sgl_rd_idx = '0, dbl_rd_idx = '0, vec_rd_idx = '0, mat_rd_idx = '0;
    logic [31:0] sgl_rd_data, vec_rd_data, mat_rd_data;
    logic [63:0] dbl_rd_data;
    logic        dbl_rd_illegal, dbl_wr_illegal;
    logic        dbl_wr_en = 0, sgl_wr_en = 0, vec_wr_en = 0, mat_wr_en = 0;
    logic [5:0]  dbl_wr_idx = '0, sgl_wr_idx = '0, vec_wr_idx = '0, mat_wr_idx = '0;
    logic [63:0] dbl_wr_data = '0;
    logic [31:0] sgl_wr_data = '0, vec_wr_data = '0, mat_wr_data = '0;

    logic [31:0] mdl [64];
    int checks = 0;
    int misses = 0;

    always #5 clk = ~clk;

    fpr_multiview i_fpr_multiview (
        .clk(clk), .rst_n(rst_n),
        .sgl_rd_idx(sgl_rd_idx), .sgl_rd_data(sgl_rd_data),
        .dbl_rd_idx(dbl_rd_idx), .dbl_rd_data(dbl_rd_data), .dbl_rd_illegal(dbl_rd_illegal),
        .vec_rd_idx(vec_rd_idx), .vec_rd_data(vec_rd_data),
        .mat_rd_idx(mat_rd_idx), .mat_rd_data(mat_rd_data),
        .dbl_wr_en(dbl_wr_en), .dbl_wr_idx(dbl_wr_idx), .dbl_wr_data(dbl_wr_data),
        .dbl_wr_illegal(dbl_wr_illegal),
        .sgl_wr_en(sgl_wr_en), .sgl_wr_idx(sgl_wr_idx), .sgl_wr_data(sgl_wr_data),
        .vec_wr_en(vec_wr_en), .vec_wr_idx(vec_wr_idx), .vec_wr_data(vec_wr_data),
        .mat_wr_en(mat_wr_en), .mat_wr_idx(mat_wr_idx), .mat_wr_data(mat_wr_data)
    );

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, misses);
        $finish;
    endtask

    // Sweep the whole array through the single view against the model.
    task automatic check_all(input string rq);
        for (int i = 0; i < 64; i++) begin
            sgl_rd_idx = 6'(i);
            #1;
            check(rq, {32'h0, sgl_rd_data}, {32'h0, mdl[i]});
        end
    endtask

    // Apply one cycle of write requests; the model keeps only the winner.
    task automatic do_write(
        input logic de, input logic [5:0] di, input logic [63:0] dd,
        input logic se, input logic [5:0] si, input logic [31:0] sd,
        input logic ve, input logic [5:0] vi, input logic [31:0] vd,
        input logic me, input logic [5:0] mi, input logic [31:0] md);
        @(negedge clk);
        dbl_wr_en = de; dbl_wr_idx = di; dbl_wr_data = dd;
        sgl_wr_en = se; sgl_wr_idx = si; sgl_wr_data = sd;
        vec_wr_en = ve; vec_wr_idx = vi; vec_wr_data = vd;
        mat_wr_en = me; mat_wr_idx = mi; mat_wr_data = md;
        if (de) begin
            if (di != 6'd63) begin
                mdl[di]     = dd[63:32];
                mdl[di + 1] = dd[31:0];
            end
        end else if (se) mdl[si] = sd;
        else if (ve) mdl[(vi & 6'd15) * 4] = vd;
        else if (me) mdl[(mi & 6'd3) * 16] = md;
        @(posedge clk);
        @(negedge clk);
        dbl_wr_en = 0; sgl_wr_en = 0; vec_wr_en = 0; mat_wr_en = 0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        check_all("R1 reset clears all registers");
    endtask

    task automatic t_single;
        do_write(0, 0, 0, 1, 6'd5, 32'hA5A5_0005, 0, 0, 0, 0, 0, 0);
        do_write(0, 0, 0, 1, 6'd63, 32'h6363_6363, 0, 0, 0, 0, 0, 0);
        do_write(0, 0, 0, 1, 6'd0, 32'h0000_F00D, 0, 0, 0, 0, 0, 0);
        check_all("R2 single writes");
        // Same-cycle read returns the old value; the new value follows the edge.
        @(negedge clk);
        sgl_wr_en = 1; sgl_wr_idx = 6'd7; sgl_wr_data = 32'h7777_1234; sgl_rd_idx = 6'd7;
        #1 check("R2 read during write sees old", {32'h0, sgl_rd_data}, 64'h0);
        @(posedge clk);
        #1 check("R2 read after write sees new", {32'h0, sgl_rd_data}, 64'h7777_1234);
        mdl[7] = 32'h7777_1234;
        @(negedge clk);
        sgl_wr_en = 0;
    endtask

    task automatic t_double;
        do_write(1, 6'd10, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check_all("R4 double write halves");
        do_write(0, 0, 0, 1, 6'd12, 32'h1212_1212, 0, 0, 0, 0, 0, 0);
        dbl_rd_idx = 6'd10;
        #1 check("R3 double read even", dbl_rd_data, 64'hDEAD_BEEF_CAFE_F00D);
        dbl_rd_idx = 6'd11;
        #1 check("R3 double read odd", dbl_rd_data, {mdl[11], mdl[12]});
        check("R3 legal flag low", {63'h0, dbl_rd_illegal}, 64'h0);
        do_write(1, 6'd62, 64'h0102_0304_0506_0708, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check_all("R4 double write at top legal index");
    endtask

    task automatic t_vector;
        do_write(0, 0, 0, 0, 0, 0, 1, 6'h23, 32'hBEC0_0003, 0, 0, 0);
        check_all("R6 vector write masked index 0x23 to register 12");
        do_write(0, 0, 0, 1, 6'd60, 32'h6060_6060, 0, 0, 0, 0, 0, 0);
        vec_rd_idx = 6'h3F;
        #1 check("R6 vector read 0x3F reaches register 60", {32'h0, vec_rd_data}, 64'h6060_6060);
        vec_rd_idx = 6'h03;
        #1 check("R6 vector read 3 reaches register 12", {32'h0, vec_rd_data}, 64'hBEC0_0003);
    endtask

    task automatic t_matrix;
        do_write(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6'h2E, 32'hAA77_0032);
        check_all("R7 matrix write masked index 0x2E to register 32");
        do_write(0, 0, 0, 1, 6'd48, 32'h4848_4848, 0, 0, 0, 0, 0, 0);
        mat_rd_idx = 6'h07;
        #1 check("R7 matrix read 7 reaches register 48", {32'h0, mat_rd_data}, 64'h4848_4848);
        mat_rd_idx = 6'h3E;
        #1 check("R7 matrix read 0x3E reaches register 32", {32'h0, mat_rd_data}, 64'hAA77_0032);
    endtask

    task automatic t_priority;
        do_write(1, 6'd20, 64'h2020_2020_2121_2121, 1, 6'd30, 32'h3030_0000,
                 1, 6'd9, 32'h0909_0000, 1, 6'd1, 32'h1616_0000);
        check_all("R8 double beats all others");
        do_write(0, 0, 0, 1, 6'd31, 32'h3131_0000,
                 1, 6'd5, 32'h0505_0000, 1, 6'd3, 32'h3C3C_0000);
        check_all("R8 single beats vector and matrix");
        do_write(0, 0, 0, 0, 0, 0, 1, 6'd6, 32'h0606_0000, 1, 6'd2, 32'h2222_0000);
        check_all("R8 vector beats matrix");
        // Overlapping targets: double at 14 and single at 15.
        do_write(1, 6'd14, 64'h1414_1414_1515_1515, 1, 6'd15, 32'hBAD0_BAD0, 0, 0, 0, 0, 0, 0);
        check_all("R8 overlapping double and single");
    endtask

    task automatic t_illegal;
        @(negedge clk);
        dbl_wr_en = 1; dbl_wr_idx = 6'd63; dbl_wr_data = 64'hFFFF_0000_FFFF_0000;
        sgl_wr_en = 1; sgl_wr_idx = 6'd40; sgl_wr_data = 32'h4040_4040;
        #1 check("R5 write illegal flag", {63'h0, dbl_wr_illegal}, 64'h1);
        @(posedge clk);
        @(negedge clk);
        dbl_wr_en = 0; sgl_wr_en = 0;
        #1 check("R5 flag drops with request", {63'h0, dbl_wr_illegal}, 64'h0);
        check_all("R10 illegal double blocks single and writes nothing");
        dbl_rd_idx = 6'd63;
        #1 check("R5 read illegal flag", {63'h0, dbl_rd_illegal}, 64'h1);
        check("R5 read at last index", dbl_rd_data, {mdl[63], 32'h0});
    endtask

    task automatic t_idle;
        do_write(0, 6'd2, 64'hFFFF_FFFF_FFFF_FFFF, 0, 6'd2, 32'hFFFF_FFFF,
                 0, 6'd1, 32'hFFFF_FFFF, 0, 6'd1, 32'hFFFF_FFFF);
        check_all("R9 idle inputs change nothing");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_double();
        t_vector();
        t_matrix();
        t_priority();
        t_illegal();
        t_idle();
        summary();
    end

endmodule